// File: doc/BRIEF.md
# Vector Condition-Field Loop Sequencer

This block walks a vectorised condition-field operation across a run of element positions, one element per clock. A start pulse captures the vector length, a mode field, two predicate masks and a reduction operator. The block then presents an element index to an external execution stub. The stub answers in the same cycle with a 4-bit condition field result. For each element the sequencer decides whether to write the result, write a zero value, skip the element, fold the result into a scalar accumulator, or stop the loop early.

Four modes are decoded from the mode field. Simple mode applies predicates and zeroing. Reduce mode accumulates an OR, XOR or AND of the results into one scalar destination, and XOR gives parity. The two early-exit modes test one bit of each result and cut the vector length at the first element that fails the test. The early-exit test can be inverted. The cut can either keep or drop the failing element. The loop can also run from the top index downward. When the loop completes or is cut, a one-cycle done pulse is raised, and the resulting vector length is held on an output.

Top module: `crv_loop_seq`

## Requirements
- R1: After start is sampled with vector length n (1 to MAX_VL), `elem_vld_o` is high for n consecutive cycles with `elem_idx_o` = 0,1,...,n-1. Each step's write appears one cycle after its step. `done_o` rises with the last step's write, and `final_vl_o` then equals n. The mode field layout is [4]=order/inclusive, [3]=early-exit select, [2]=reduce/invert, [1:0]=dz,sz or tested bit.
- R2: With mode[3]=0 and mode[4]=1, the elements are visited in the order n-1 down to 0.
- R3: In simple mode (mode[3:2]=00), an element with both mask bits set is written with `cr_res_i` at its own index. An element whose destination mask bit is 0 is written with the zero value when dz (mode[1]) is 1, and skipped otherwise. An element whose destination mask bit is 1 and source mask bit is 0 is written with the zero value when sz (mode[0]) is 1, and skipped otherwise. In the non-early-exit modes the zero value is 4'b0000.
- R4: In the early-exit modes, when `snz_i`=1 the zero value is 4'b0001 instead of 4'b0000.
- R5: In 3-bit early-exit mode (mode[3]=1, `ff_wide_i`=0), the tested bit is `cr_res_i[mode[1:0]]` and mode[2] inverts it. Both dz and sz equal `zz_i`. On the first active element whose bit equals mode[2], that element is not written. The loop then stops, and `final_vl_o` equals the number of elements visited before it.
- R6: In an early-exit mode with mode[4]=1, the failing element is written with its result, and `final_vl_o` counts it.
- R7: In 5-bit early-exit mode (mode[3]=1, `ff_wide_i`=1), the tested bit is `cr_res_i[IMPL_BIT]` (default 2). dz and sz come from mode[1:0], and `zz_i` has no effect.
- R8: In reduce mode (mode[3:2]=01), an accumulator starts at 4'b0000 for OR and XOR and at 4'b1111 for AND. Each element with both mask bits set updates the accumulator and writes the new value to index 0. All other elements are skipped. `red_op_i` selects the operator: 00 OR, 01 XOR, 1x AND.
- R9: When the vector length is 0, `done_o` is high in the cycle after start, there are no steps and no writes, and `final_vl_o` is 0. `final_vl_o` changes only together with `done_o`.
- R10: A vector length above MAX_VL is treated as MAX_VL.
- R11: `done_o` is high for one cycle only. A start that arrives while a loop is running has no effect on that loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| vl_i | input | VL_W | Requested vector length |
| mode_i | input | 5 | Mode field |
| zz_i | input | 1 | Combined zeroing for 3-bit early-exit mode |
| snz_i | input | 1 | Zero value becomes 1 in early-exit modes |
| ff_wide_i | input | 1 | Selects 5-bit early-exit variant |
| red_op_i | input | 2 | Reduction operator |
| src_mask_i | input | MAX_VL | Source predicate mask |
| dst_mask_i | input | MAX_VL | Destination predicate mask |
| cr_res_i | input | 4 | Result from execution stub for current index |
| elem_vld_o | output | 1 | A step is in progress |
| elem_idx_o | output | IDX_W | Element index of current step |
| wr_en_o | output | 1 | Destination write strobe |
| wr_idx_o | output | IDX_W | Destination element index |
| wr_data_o | output | 4 | Destination write data |
| final_vl_o | output | VL_W | Resulting vector length |
| done_o | output | 1 | One-cycle loop-complete pulse |

## Verification
The bench builds the block with MAX_VL=8 and leaves IMPL_BIT at 2. The length port is then four bits wide, so lengths of 9 to 15 can be driven and the clamp to MAX_VL is reachable. With eight elements, every mask pattern used in the bench fits in one byte. An early exit can be placed at the first element, in the middle of the vector, or not at all, within a short run.

// File: rtl/crv_pkg.sv
package crv_pkg;

   typedef enum logic [1:0] {
      CRV_SIMPLE = 2'd0,
      CRV_REDUCE = 2'd1,
      CRV_FF3    = 2'd2,
      CRV_FF5    = 2'd3
   } crv_mode_e;

   typedef struct packed {
      crv_mode_e  mode;
      logic       rev;
      logic       vli;
      logic       inv;
      logic [1:0] tbit;
      logic       dz;
      logic       sz;
      logic       snz;
   } crv_cfg_t;

   function automatic logic [3:0] crv_reduce(input logic [1:0] op,
                                             input logic [3:0] a,
                                             input logic [3:0] b);
      case (op)
         2'b00:   return a | b;
         2'b01:   return a ^ b;
         default: return a & b;
      endcase
   endfunction

   function automatic logic [3:0] crv_red_init(input logic [1:0] op);
      return op[1] ? 4'hF : 4'h0;
   endfunction

endpackage

// File: rtl/crv_mode_dec.sv
module crv_mode_dec
   import crv_pkg::*;
#(
   parameter int IMPL_BIT = 2
) (
   input  logic [4:0] mode_i,
   input  logic       zz_i,
   input  logic       snz_i,
   input  logic       wide_i,
   output crv_cfg_t   cfg_o
);

   localparam logic [1:0] IMPL_SEL = 2'(IMPL_BIT);

   always_comb begin
      cfg_o      = '0;
      cfg_o.inv  = mode_i[2];
      if (!mode_i[3]) begin
         cfg_o.mode = mode_i[2] ? CRV_REDUCE : CRV_SIMPLE;
         cfg_o.rev  = mode_i[4];
         cfg_o.dz   = mode_i[1];
         cfg_o.sz   = mode_i[0];
      end else begin
         cfg_o.vli = mode_i[4];
         cfg_o.snz = snz_i;
         if (wide_i) begin
            cfg_o.mode = CRV_FF5;
            cfg_o.tbit = IMPL_SEL;
            cfg_o.dz   = mode_i[1];
            cfg_o.sz   = mode_i[0];
         end else begin
            cfg_o.mode = CRV_FF3;
            cfg_o.tbit = mode_i[1:0];
            cfg_o.dz   = zz_i;
            cfg_o.sz   = zz_i;
         end
      end
   end

endmodule

// File: rtl/crv_elem_eval.sv
module crv_elem_eval
   import crv_pkg::*;
(
   input  crv_cfg_t   cfg_i,
   input  logic       src_bit_i,
   input  logic       dst_bit_i,
   input  logic [3:0] res_i,
   input  logic [3:0] acc_i,
   input  logic [1:0] op_i,
   output logic       wr_o,
   output logic [3:0] wdata_o,
   output logic       fail_o,
   output logic       acc_upd_o,
   output logic [3:0] acc_nxt_o
);

   logic active;
   logic zap;
   logic pass;
   logic is_ff;

   assign active = src_bit_i & dst_bit_i;
   assign zap    = (~dst_bit_i & cfg_i.dz) | (dst_bit_i & ~src_bit_i & cfg_i.sz);
   assign pass   = res_i[cfg_i.tbit] ^ cfg_i.inv;
   assign is_ff  = (cfg_i.mode == CRV_FF3) || (cfg_i.mode == CRV_FF5);

   always_comb begin
      wr_o      = 1'b0;
      wdata_o   = res_i;
      fail_o    = 1'b0;
      acc_upd_o = 1'b0;
      acc_nxt_o = crv_reduce(op_i, acc_i, res_i);
      if (cfg_i.mode == CRV_REDUCE) begin
         if (active) begin
            acc_upd_o = 1'b1;
            wr_o      = 1'b1;
            wdata_o   = acc_nxt_o;
         end
      end else if (active) begin
         if (is_ff && !pass) begin
            fail_o = 1'b1;
            wr_o   = cfg_i.vli;
         end else begin
            wr_o = 1'b1;
         end
      end else if (zap) begin
         wr_o    = 1'b1;
         wdata_o = {3'b000, cfg_i.snz};
      end
   end

endmodule

// File: rtl/crv_step_ctr.sv
module crv_step_ctr #(
   parameter int VL_W  = 5,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             adv_i,
   input  logic [VL_W-1:0]  n_i,
   input  logic             rev_i,
   output logic [VL_W-1:0]  cnt_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             last_o
);

   logic [VL_W-1:0] cnt_q;
   logic [VL_W-1:0] pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= '0;
      end else if (adv_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign pos    = rev_i ? (n_i - 1'b1 - cnt_q) : cnt_q;
   assign idx_o  = pos[IDX_W-1:0];
   assign cnt_o  = cnt_q;
   assign last_o = (cnt_q == n_i - 1'b1);

endmodule

// File: rtl/crv_loop_seq.sv
module crv_loop_seq
   import crv_pkg::*;
#(
   parameter int MAX_VL   = 16,
   parameter int IMPL_BIT = 2,
   localparam int VL_W    = $clog2(MAX_VL + 1),
   localparam int IDX_W   = $clog2(MAX_VL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [VL_W-1:0]   vl_i,
   input  logic [4:0]        mode_i,
   input  logic              zz_i,
   input  logic              snz_i,
   input  logic              ff_wide_i,
   input  logic [1:0]        red_op_i,
   input  logic [MAX_VL-1:0] src_mask_i,
   input  logic [MAX_VL-1:0] dst_mask_i,
   input  logic [3:0]        cr_res_i,
   output logic              elem_vld_o,
   output logic [IDX_W-1:0]  elem_idx_o,
   output logic              wr_en_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic [3:0]        wr_data_o,
   output logic [VL_W-1:0]   final_vl_o,
   output logic              done_o
);

   generate
      if (MAX_VL < 2) begin : g_bad_maxvl
         $error("crv_loop_seq: MAX_VL must be at least 2");
      end
      if (IMPL_BIT < 0 || IMPL_BIT > 3) begin : g_bad_bit
         $error("crv_loop_seq: IMPL_BIT must select one of four field bits");
      end
   endgenerate

   localparam logic [VL_W-1:0] MAX_VL_V = VL_W'(MAX_VL);

   crv_cfg_t          cfg_in;
   crv_cfg_t          cfg_q;
   logic              busy_q;
   logic [VL_W-1:0]   n_q;
   logic [MAX_VL-1:0] src_q;
   logic [MAX_VL-1:0] dst_q;
   logic [1:0]        op_q;
   logic [3:0]        acc_q;
   logic [VL_W-1:0]   vl_clamp;
   logic              accept;
   logic [VL_W-1:0]   cnt;
   logic [IDX_W-1:0]  idx;
   logic              last;
   logic              ev_wr;
   logic [3:0]        ev_wdata;
   logic              ev_fail;
   logic              ev_acc_upd;
   logic [3:0]        ev_acc_nxt;

   assign vl_clamp = (vl_i > MAX_VL_V) ? MAX_VL_V : vl_i;
   assign accept   = start_i & ~busy_q;

   crv_mode_dec #(.IMPL_BIT(IMPL_BIT)) u_dec (
      .mode_i (mode_i),
      .zz_i   (zz_i),
      .snz_i  (snz_i),
      .wide_i (ff_wide_i),
      .cfg_o  (cfg_in)
   );

   crv_step_ctr #(.VL_W(VL_W), .IDX_W(IDX_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .adv_i  (busy_q),
      .n_i    (n_q),
      .rev_i  (cfg_q.rev),
      .cnt_o  (cnt),
      .idx_o  (idx),
      .last_o (last)
   );

   crv_elem_eval u_eval (
      .cfg_i     (cfg_q),
      .src_bit_i (src_q[idx]),
      .dst_bit_i (dst_q[idx]),
      .res_i     (cr_res_i),
      .acc_i     (acc_q),
      .op_i      (op_q),
      .wr_o      (ev_wr),
      .wdata_o   (ev_wdata),
      .fail_o    (ev_fail),
      .acc_upd_o (ev_acc_upd),
      .acc_nxt_o (ev_acc_nxt)
   );

   assign elem_vld_o = busy_q;
   assign elem_idx_o = idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         cfg_q      <= '0;
         n_q        <= '0;
         src_q      <= '0;
         dst_q      <= '0;
         op_q       <= '0;
         acc_q      <= '0;
         wr_en_o    <= 1'b0;
         wr_idx_o   <= '0;
         wr_data_o  <= '0;
         final_vl_o <= '0;
         done_o     <= 1'b0;
      end else begin
         done_o  <= 1'b0;
         wr_en_o <= 1'b0;
         if (accept) begin
            cfg_q <= cfg_in;
            n_q   <= vl_clamp;
            src_q <= src_mask_i;
            dst_q <= dst_mask_i;
            op_q  <= red_op_i;
            acc_q <= crv_red_init(red_op_i);
            if (vl_clamp == '0) begin
               done_o     <= 1'b1;
               final_vl_o <= '0;
            end else begin
               busy_q <= 1'b1;
            end
         end else if (busy_q) begin
            wr_en_o   <= ev_wr;
            wr_idx_o  <= (cfg_q.mode == CRV_REDUCE) ? '0 : idx;
            wr_data_o <= ev_wdata;
            if (ev_acc_upd) begin
               acc_q <= ev_acc_nxt;
            end
            if (ev_fail) begin
               busy_q     <= 1'b0;
               done_o     <= 1'b1;
               final_vl_o <= cnt + VL_W'(cfg_q.vli);
            end else if (last) begin
               busy_q     <= 1'b0;
               done_o     <= 1'b1;
               final_vl_o <= n_q;
            end
         end
      end
   end

endmodule

// File: rtl/crv_loop_seq_chk.sv
module crv_loop_seq_chk #(
   parameter int MAX_VL = 16,
   parameter int VL_W   = 5,
   parameter int IDX_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             elem_vld_o,
   input logic [IDX_W-1:0] elem_idx_o,
   input logic             wr_en_o,
   input logic [IDX_W-1:0] wr_idx_o,
   input logic [VL_W-1:0]  final_vl_o,
   input logic             done_o
);

   localparam logic [VL_W:0] LIMIT = (VL_W + 1)'(MAX_VL);

   // R11: completion indication lasts one cycle
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R1: a write is always the consequence of a step in the cycle before
   p_wr_after_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> $past(elem_vld_o));

   // R2: consecutive steps visit neighbouring indices in either direction
   p_idx_adjacent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_vld_o && $past(elem_vld_o)) |->
         ((elem_idx_o == IDX_W'($past(elem_idx_o) + 1'b1)) ||
          (elem_idx_o == IDX_W'($past(elem_idx_o) - 1'b1))));

   // R10: resulting length never exceeds the limit
   p_final_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ({1'b0, final_vl_o} <= LIMIT));

   // R9: no step continues once the loop has reported completion
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !elem_vld_o);

   // R9: resulting length moves only with the completion pulse
   p_final_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(final_vl_o));

   // R1: write index is a legal element position
   p_wr_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> ({1'b0, wr_idx_o} < (IDX_W + 1)'(MAX_VL)));

endmodule

bind crv_loop_seq crv_loop_seq_chk #(
   .MAX_VL (MAX_VL),
   .VL_W   (VL_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .elem_vld_o (elem_vld_o),
   .elem_idx_o (elem_idx_o),
   .wr_en_o    (wr_en_o),
   .wr_idx_o   (wr_idx_o),
   .final_vl_o (final_vl_o),
   .done_o     (done_o)
);

// File: tb/tb_crv_loop_seq.sv
`timescale 1ns/1ps
module tb_crv_loop_seq;

   localparam int NV = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [3:0]    vl_i = '0;
   logic [4:0]    mode_i = '0;
   logic          zz_i = 1'b0;
   logic          snz_i = 1'b0;
   logic          ff_wide_i = 1'b0;
   logic [1:0]    red_op_i = '0;
   logic [NV-1:0] src_mask_i = '0;
   logic [NV-1:0] dst_mask_i = '0;
   logic [3:0]    cr_res_i;
   logic          elem_vld_o;
   logic [2:0]    elem_idx_o;
   logic          wr_en_o;
   logic [2:0]    wr_idx_o;
   logic [3:0]    wr_data_o;
   logic [3:0]    final_vl_o;
   logic          done_o;

   logic [3:0] tbl [NV];
   logic [6:0] expq [$];
   string      cur_tag = "R1";
   int         total = 0;
   int         bad = 0;

   always #4 clk = ~clk;

   always_comb cr_res_i = tbl[elem_idx_o];

   crv_loop_seq #(.MAX_VL(NV), .IMPL_BIT(2)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .vl_i       (vl_i),
      .mode_i     (mode_i),
      .zz_i       (zz_i),
      .snz_i      (snz_i),
      .ff_wide_i  (ff_wide_i),
      .red_op_i   (red_op_i),
      .src_mask_i (src_mask_i),
      .dst_mask_i (dst_mask_i),
      .cr_res_i   (cr_res_i),
      .elem_vld_o (elem_vld_o),
      .elem_idx_o (elem_idx_o),
      .wr_en_o    (wr_en_o),
      .wr_idx_o   (wr_idx_o),
      .wr_data_o  (wr_data_o),
      .final_vl_o (final_vl_o),
      .done_o     (done_o)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   // monitor: pops expected writes as the design produces them
   always @(negedge clk) begin
      if (rst_n && wr_en_o) begin
         if (expq.size() == 0) begin
            check(cur_tag, "unexpected write idx", int'(wr_idx_o), -1);
         end else begin
            logic [6:0] e;
            e = expq.pop_front();
            check(cur_tag, "write idx", int'(wr_idx_o), int'(e[6:4]));
            check(cur_tag, "write data", int'(wr_data_o), int'(e[3:0]));
         end
      end
   end

   task automatic run(input string tag, input int vl, input logic [4:0] md,
                      input logic zz, input logic snz, input logic wide,
                      input logic [1:0] op, input logic [NV-1:0] sm,
                      input logic [NV-1:0] dm, input bit hold2);
      int n, steps, fvl, lat;
      logic ff, rev, red, vli, inv, dz, sz, zv, stop;
      logic [1:0] tb;
      logic [3:0] acc;
      n = (vl > NV) ? NV : vl;
      ff = md[3]; rev = !ff && md[4]; red = !ff && md[2];
      vli = ff && md[4]; inv = md[2];
      if (!ff) begin dz = md[1]; sz = md[0]; zv = 1'b0; tb = 2'd0; end
      else if (wide) begin dz = md[1]; sz = md[0]; zv = snz; tb = 2'd2; end
      else begin dz = zz; sz = zz; zv = snz; tb = md[1:0]; end
      acc = op[1] ? 4'hF : 4'h0;
      steps = 0; fvl = n; stop = 1'b0;
      for (int k = 0; k < n; k++) begin
         int i;
         logic act;
         if (!stop) begin
            i = rev ? (n - 1 - k) : k;
            steps = k + 1;
            act = sm[i] && dm[i];
            if (red) begin
               if (act) begin
                  case (op)
                     2'b00:   acc = acc | tbl[i];
                     2'b01:   acc = acc ^ tbl[i];
                     default: acc = acc & tbl[i];
                  endcase
                  expq.push_back({3'd0, acc});
               end
            end else if (act) begin
               if (ff && (tbl[i][tb] == inv)) begin
                  if (vli) expq.push_back({3'(i), tbl[i]});
                  fvl = k + (vli ? 1 : 0);
                  stop = 1'b1;
               end else begin
                  expq.push_back({3'(i), tbl[i]});
               end
            end else if ((!dm[i] && dz) || (dm[i] && !sm[i] && sz)) begin
               expq.push_back({3'(i), {3'b000, zv}});
            end
         end
      end
      cur_tag = tag;
      vl_i = 4'(vl); mode_i = md; zz_i = zz; snz_i = snz; ff_wide_i = wide;
      red_op_i = op; src_mask_i = sm; dst_mask_i = dm;
      start_i = 1'b1;
      lat = 0;
      while (lat < 40) begin
         @(negedge clk);
         lat++;
         if (done_o) break;
         if (lat == 1 && hold2) begin
            vl_i = 4'd2; mode_i = 5'b10000; src_mask_i = '0; dst_mask_i = '0;
         end else begin
            start_i = 1'b0;
         end
      end
      start_i = 1'b0;
      check(tag, "done latency", lat, steps + 1);
      check(tag, "final vl", int'(final_vl_o), fvl);
      @(negedge clk);
      check("R11", "done after pulse", int'(done_o), 0);
      check(tag, "writes left", expq.size(), 0);
      expq.delete();
      repeat (2) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < NV; i++) tbl[i] = 4'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "reset wr_en", int'(wr_en_o), 0);
      check("R1", "reset done", int'(done_o), 0);
      check("R1", "reset vld", int'(elem_vld_o), 0);
      check("R9", "reset final vl", int'(final_vl_o), 0);

      tbl = '{4'h5, 4'hA, 4'h3, 4'hC, 4'h9, 4'h6, 4'hF, 4'h1};
      // R1 forward simple
      run("R1", 5, 5'b00000, 0, 0, 0, 2'b00, 8'hFF, 8'hFF, 0);
      // R2 reverse order
      run("R2", 6, 5'b10000, 0, 0, 0, 2'b00, 8'hFF, 8'hFF, 0);
      // R3 masking with dz, with sz, with neither
      run("R3", 8, 5'b00010, 0, 0, 0, 2'b00, 8'b1101_0111, 8'b0111_1011, 0);
      run("R3", 8, 5'b00001, 0, 0, 0, 2'b00, 8'b1101_0111, 8'b0111_1011, 0);
      run("R3", 8, 5'b00000, 0, 1, 0, 2'b00, 8'b1101_0111, 8'b0111_1011, 0);
      // R5 3-bit early exit, exclusive, fail in the middle
      tbl = '{4'h2, 4'h3, 4'h6, 4'h1, 4'h2, 4'h3, 4'h6, 4'h7};
      run("R5", 7, 5'b01001, 0, 0, 0, 2'b00, 8'hFF, 8'hFF, 0);
      // R6 inclusive variant
      run("R6", 7, 5'b11001, 0, 0, 0, 2'b00, 8'hFF, 8'hFF, 0);
      // R5 inverted test failing on first element
      tbl = '{4'h5, 4'hA, 4'h3, 4'hC, 4'h9, 4'h6, 4'hF, 4'h1};
      run("R5", 8, 5'b01100, 0, 0, 0, 2'b00, 8'hFF, 8'hFF, 0);
      // R4 substitute one in zeroed elements, no failure
      for (int i = 0; i < NV; i++) tbl[i] = 4'hE;
      run("R4", 8, 5'b01011, 1, 1, 0, 2'b00, 8'b1111_0110, 8'b1011_1111, 0);
      // R7 5-bit variant, implied bit 2, zz ignored
      for (int i = 0; i < NV; i++) tbl[i] = 4'h4;
      tbl[5] = 4'h0;
      run("R7", 8, 5'b01010, 1, 1, 1, 2'b00, 8'b1111_1110, 8'b1111_1011, 0);
      // R8 reductions
      tbl = '{4'h5, 4'hA, 4'h3, 4'hC, 4'h9, 4'h6, 4'hF, 4'h1};
      run("R8", 8, 5'b00100, 0, 0, 0, 2'b00, 8'b0110_1101, 8'hFF, 0);
      run("R8", 8, 5'b00111, 0, 0, 0, 2'b01, 8'hFF, 8'b1011_1110, 0);
      run("R8", 6, 5'b10100, 0, 0, 0, 2'b10, 8'hFF, 8'b0011_1101, 0);
      // R9 empty vector
      run("R9", 0, 5'b00010, 0, 0, 0, 2'b00, 8'hFF, 8'h00, 0);
      // R10 clamp, forward and reverse
      run("R10", 13, 5'b00000, 0, 0, 0, 2'b00, 8'hFF, 8'hFF, 0);
      run("R10", 15, 5'b10000, 0, 0, 0, 2'b00, 8'hFF, 8'hFF, 0);
      // R11 second start during a run is ignored
      run("R11", 5, 5'b00000, 0, 0, 0, 2'b00, 8'hFF, 8'hFF, 1);

      report();
      $finish;
   end

   initial begin
      #(200000 * 8);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
   end

endmodule